// File: doc/BRIEF.md
# Serial Video Descrambler and Word Aligner

This block sits right after clock and data recovery on a standard-definition serial digital video receiver. It accepts one recovered line bit per cycle in which a valid strobe is high. It returns the 10-bit parallel words that the transmitter serialised.

Each accepted bit first goes through NRZI decoding, which turns line transitions back into bit values. It then passes a feed-forward descrambler built on x^9 + x^4 + 1. This descrambler needs no seed, and it flushes any corrupted input within ten bits. Last, the descrambled bits shift into a 30-bit window. The window looks for the timing reference: ten ones followed by twenty zeros, which is the words 3FF, 000, 000. It may start at any bit position.

A reference sets the 10-bit word boundary. Lock follows from seeing references again at that boundary. While locked, a lone reference at a new offset cannot slip the boundary. The boundary moves only if the new offset repeats.

Top module: `sdd_rx_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `word_vld`, `locked` and `trs_found` are 0 and `word_out` is 0.
- R2: Line coding is NRZI: a transition on the line is a 1 and no transition is a 0. The line level before the first bit counts as 0. Scrambling is s[n] = d[n] ^ s[n-4] ^ s[n-9], with a history of zeros at the start. After a reference, the words on `word_out` equal the words the transmitter sent.
- R3: Bits travel LSB first. The 10 bits that follow the last bit of a reference form the first word after it, and bit 0 of that word is the first bit received.
- R4: `trs_found` pulses high for exactly one cycle for each occurrence of 10 ones followed by 20 zeros in the descrambled stream, at any bit offset. The pulse comes in the cycle after the valid edge of the last zero.
- R5: A cycle with `bit_vld` low changes no state. Gaps between bits do not change the recovered words.
- R6: `locked` rises only when a second reference is found at the same offset as the reference before it. One reference alone leaves `locked` at 0.
- R7: While locked, a single reference at a new offset leaves the word boundary and `locked` unchanged. A second reference at that same new offset moves the boundary, and the words after it are correct.
- R8: While locked, each run of MISS_WIN (default 512) valid bits that contains no reference at the expected offset counts as one miss. `locked` falls on the MISS_LIMIT-th (default 2) consecutive miss.
- R9: After one corrupted line bit, the words that start more than 10 bits after the error are correct again, and `locked` stays 1.
- R10: `word_vld` pulses for one cycle per 10 valid bits. The pulse comes in the cycle after the valid edge of the tenth bit of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies `line_bit` in this cycle |
| line_bit | input | 1 | Recovered NRZI line bit |
| word_out | output | 10 | Recovered word, LSB received first |
| word_vld | output | 1 | One-cycle strobe for `word_out` |
| locked | output | 1 | Word boundary confirmed |
| trs_found | output | 1 | One-cycle pulse on each timing reference |

## Verification
A wrong line level or a wrong descrambler history corrupts every word for up to ten bits. It then heals, so the bench compares whole payloads around injected errors instead of single words. A wrong boundary counter shows up at the next reference: the payload comes back bit-rotated, or `locked` never rises after the second frame. Faults in the lock and miss logic show up only at frame granularity, either as a slip after a single shifted reference or as a failure to drop lock within two miss windows. The bench therefore drives whole frames and long silent runs.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned TRS_W  = 3 * WORD_W;
  localparam int unsigned HIST_W = 9;   // x^9 term
  localparam int unsigned TAP_W  = 4;   // x^4 term
  localparam int unsigned PH_W   = $clog2(WORD_W);
  localparam logic [TRS_W-1:0] TRS_PAT = {{(2*WORD_W){1'b0}}, {WORD_W{1'b1}}};

  // transition on the line means 1
  function automatic logic nrzi_bit(input logic now_lvl, input logic prev_lvl);
    return now_lvl ^ prev_lvl;
  endfunction

  // feed-forward descrambler, hist[k] holds s[n-1-k]
  function automatic logic descr_bit(input logic s, input logic [HIST_W-1:0] hist);
    return s ^ hist[TAP_W-1] ^ hist[HIST_W-1];
  endfunction

  function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] ph);
    return (ph == PH_W'(WORD_W - 1)) ? '0 : ph + 1'b1;
  endfunction
endpackage

// File: rtl/sdd_nrzi_dec.sv
module sdd_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic line_bit,
  output logic nrz_bit
);
  import sdd_pkg::*;

  logic prev_q;

  assign nrz_bit = nrzi_bit(line_bit, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (bit_vld) prev_q <= line_bit;
  end

  // R5: idle cycles leave the line history alone
  a_r5_nrzi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(prev_q));
endmodule

// File: rtl/sdd_descrambler.sv
module sdd_descrambler (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic s_bit,
  output logic d_bit
);
  import sdd_pkg::*;

  logic [HIST_W-1:0] hist_q;

  assign d_bit = descr_bit(s_bit, hist_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       hist_q <= '0;
    else if (bit_vld) hist_q <= {hist_q[HIST_W-2:0], s_bit};
  end

  // R9: history is fed only from the received stream
  a_r9_feed_forward: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> hist_q[0] == $past(s_bit));
  a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(hist_q));
endmodule

// File: rtl/sdd_aligner.sv
module sdd_aligner #(
  parameter int unsigned MISS_WIN   = 512,
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_vld,
  input  logic                       d_bit,
  output logic [sdd_pkg::WORD_W-1:0] word_out,
  output logic                       word_vld,
  output logic                       locked,
  output logic                       trs_found
);
  import sdd_pkg::*;

  localparam int unsigned TMR_W = (MISS_WIN > 2) ? $clog2(MISS_WIN) : 1;
  localparam int unsigned MC_W  = $clog2(MISS_LIMIT + 1);

  logic [TRS_W-1:0] win_q;
  logic [PH_W-1:0]  phase_q, cand_ph_q;
  logic             cand_vld_q, have_ref_q, locked_q, trs_q, word_vld_q;
  logic [WORD_W-1:0] word_q;
  logic [TMR_W-1:0] tmr_q;
  logic [MC_W-1:0]  miss_q;

  // named events, used by logic and assertions alike
  logic [TRS_W-1:0] win_nxt;
  logic at_bound, match, aligned_hit, off_hit, cand_hit, realign;
  logic lock_set, tmr_end, miss_ev, drop;

  assign win_nxt     = {d_bit, win_q[TRS_W-1:1]};
  assign at_bound    = (phase_q == PH_W'(WORD_W - 1));
  assign match       = bit_vld && (win_nxt == TRS_PAT);
  assign aligned_hit = match && at_bound;
  assign off_hit     = match && !at_bound;
  assign cand_hit    = off_hit && cand_vld_q && (cand_ph_q == phase_q);
  assign realign     = off_hit && (!locked_q || cand_hit);
  assign lock_set    = !locked_q && aligned_hit && have_ref_q;
  assign tmr_end     = bit_vld && (tmr_q == TMR_W'(MISS_WIN - 1));
  assign miss_ev     = locked_q && tmr_end && !aligned_hit && !realign;
  assign drop        = miss_ev && (miss_q == MC_W'(MISS_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q      <= '0;
      phase_q    <= '0;
      word_q     <= '0;
      word_vld_q <= 1'b0;
      trs_q      <= 1'b0;
    end else begin
      word_vld_q <= bit_vld && at_bound;
      trs_q      <= match;
      if (bit_vld) begin
        win_q   <= win_nxt;
        phase_q <= realign ? '0 : next_phase(phase_q);
        if (at_bound) word_q <= win_nxt[TRS_W-1 -: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q   <= 1'b0;
      have_ref_q <= 1'b0;
      cand_vld_q <= 1'b0;
      cand_ph_q  <= '0;
      tmr_q      <= '0;
      miss_q     <= '0;
    end else begin
      if (drop)          locked_q <= 1'b0;
      else if (lock_set) locked_q <= 1'b1;

      if (drop)       have_ref_q <= 1'b0;
      else if (match) have_ref_q <= 1'b1;

      if (!locked_q || aligned_hit || realign) begin
        cand_vld_q <= 1'b0;
      end else if (off_hit) begin
        cand_vld_q <= 1'b1;
        cand_ph_q  <= phase_q;
      end

      if (!locked_q || aligned_hit || realign || drop) begin
        tmr_q  <= '0;
        miss_q <= '0;
      end else if (bit_vld) begin
        tmr_q <= tmr_end ? '0 : tmr_q + 1'b1;
        if (miss_ev) miss_q <= miss_q + 1'b1;
      end
    end
  end

  assign word_out  = word_q;
  assign word_vld  = word_vld_q;
  assign locked    = locked_q;
  assign trs_found = trs_q;

  a_r10_word_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_q |=> !word_vld_q);
  a_r4_trs_single: assert property (@(posedge clk) disable iff (!rst_n)
    trs_q |=> !trs_q);
  a_r6_lock_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> trs_q);
  a_r8_drop_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(miss_ev));
  a_r7_no_single_slip: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && off_hit && !cand_hit) |=> locked_q && (phase_q == next_phase($past(phase_q))));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(phase_q) && $stable(win_q) && $stable(tmr_q));
endmodule

// File: rtl/sdd_rx_top.sv
module sdd_rx_top #(
  parameter int unsigned MISS_WIN   = 512,
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_vld,
  input  logic                       line_bit,
  output logic [sdd_pkg::WORD_W-1:0] word_out,
  output logic                       word_vld,
  output logic                       locked,
  output logic                       trs_found
);
  logic nrz_bit, d_bit;

  sdd_nrzi_dec u_nrzi (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld),
    .line_bit(line_bit), .nrz_bit(nrz_bit)
  );

  sdd_descrambler u_descr (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld),
    .s_bit(nrz_bit), .d_bit(d_bit)
  );

  sdd_aligner #(.MISS_WIN(MISS_WIN), .MISS_LIMIT(MISS_LIMIT)) u_align (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .d_bit(d_bit),
    .word_out(word_out), .word_vld(word_vld),
    .locked(locked), .trs_found(trs_found)
  );
endmodule

// File: tb/sdd_rx_top_tb.sv
module sdd_rx_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic line_bit = 1'b0;
  logic [9:0] word_out;
  logic word_vld, locked, trs_found;

  always #10 clk = ~clk;  // 50 MHz

  sdd_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_bit(line_bit),
    .word_out(word_out), .word_vld(word_vld), .locked(locked), .trs_found(trs_found)
  );

  localparam logic [9:0] PAY [0:11] = '{10'h155, 10'h2AA, 10'h0F3, 10'h31C, 10'h1E7, 10'h248,
                                        10'h093, 10'h36D, 10'h12C, 10'h2D5, 10'h0B6, 10'h349};
  // {prefix bits[1:0], gaps, expect locked, expect payload intact}
  localparam logic [4:0] STEPS [0:4] = '{5'b11_0_0_1, 5'b00_0_1_1, 5'b00_1_1_1,
                                         5'b01_0_1_0, 5'b00_0_1_1};

  int n_chk = 0, n_err = 0;
  int words_seen = 0, trs_seen = 0, cap_n = 0;
  logic [9:0] cap [0:15];
  logic [8:0] scr = '0;
  logic lvl = 1'b0;
  bit gap_en = 0;
  int gap_ctr = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
    end
  endtask

  task automatic tx_bit(input logic d, input logic flip);
    logic s;
    if (gap_en && (gap_ctr % 7 == 6)) idle(1);
    gap_ctr++;
    s   = d ^ scr[3] ^ scr[8];
    scr = {scr[7:0], s};
    lvl = lvl ^ s;
    @(negedge clk);
    line_bit = lvl ^ flip;
    bit_vld  = 1'b1;
  endtask

  task automatic tx_word(input logic [9:0] w, input int flip_pos);
    for (int i = 0; i < 10; i++) tx_bit(w[i], i == flip_pos);
  endtask

  task automatic tx_frame(input int prefix, input int err_word);
    for (int i = 0; i < prefix; i++) tx_bit(1'b1, 1'b0);
    tx_word(10'h3FF, 99);
    tx_word(10'h000, 99);
    tx_word(10'h000, 99);
    for (int k = 0; k < 12; k++) tx_word(PAY[k], (k == err_word) ? 5 : 99);
    idle(2);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_vld) begin
        words_seen++;
        if (cap_n < 16) begin
          cap[cap_n] = word_out;
          cap_n++;
        end
      end
      if (trs_found) begin
        trs_seen++;
        cap_n = 0;
      end
    end
  end

  task automatic chk_payload(input string req, input int skip_lo, input int skip_hi);
    for (int k = 0; k < 12; k++)
      if (k < skip_lo || k > skip_hi) chk(req, {22'd0, cap[k]}, {22'd0, PAY[k]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int t0, w0;
    repeat (4) @(negedge clk);
    // R1: reset state, held and just after release
    chk("R1 held", {29'd0, word_vld, locked, trs_found}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 released", {19'd0, word_out, word_vld, locked, trs_found}, 32'd0);

    for (int s = 0; s < 5; s++) begin
      logic [4:0] st;
      st = STEPS[s];
      gap_en = st[2];
      t0 = trs_seen;
      w0 = words_seen;
      tx_frame(int'(st[4:3]), 99);
      gap_en = 0;
      chk("R4 one pulse per reference", trs_seen - t0, 1);
      chk(st[1] ? "R6 locked" : "R6 not locked on one ref", {31'd0, locked}, {31'd0, st[1]});
      if (st[0]) chk_payload("R2 R3 payload", 99, -1);
      else chk("R7 single shifted ref ignored", {31'd0, cap[0] != PAY[0]}, 32'd1);
      if (s == 1) chk("R10 words per aligned frame", words_seen - w0, 15);
      if (s == 2) chk("R5 gaps harmless", {22'd0, cap[11]}, {22'd0, PAY[11]});
    end

    // R9: one corrupted line bit inside payload word 4
    tx_frame(0, 4);
    chk_payload("R9 words outside error span", 4, 5);
    chk("R9 lock kept", {31'd0, locked}, 32'd1);
    tx_frame(0, 99);
    chk_payload("R9 next frame clean", 99, -1);

    // R8: silence shorter than one window keeps lock, longer runs drop it
    for (int k = 0; k < 30; k++) tx_word(PAY[k % 12], 99);
    idle(2);
    chk("R8 lock held under window", {31'd0, locked}, 32'd1);
    for (int k = 0; k < 100; k++) tx_word(PAY[k % 12], 99);
    idle(2);
    chk("R8 lock dropped", {31'd0, locked}, 32'd0);

    // R6: relock needs two references
    tx_frame(0, 99);
    chk("R6 one ref after drop", {31'd0, locked}, 32'd0);
    tx_frame(0, 99);
    chk("R6 relocked", {31'd0, locked}, 32'd1);
    chk_payload("R3 payload after relock", 99, -1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule